// File: doc/BRIEF.md
# Four-Entry Instruction Address Translation Cache

This block is a small, fully associative translation cache that sits on the instruction fetch path. It holds four page translations. Each cycle it compares a fetch address against all of them in parallel and reports one of three outcomes: a single match, no match, or more than one match. On a single match it also reports the entry index, the translated physical address and the entry's user-execute permission. Pages can be 1 KB, 4 KB, 64 KB or 1 MB.

Recency is tracked in a six-bit pairwise ordering field. Each single-match lookup applies a fixed clear/set pattern for the entry that matched, and a replacement victim is decoded from that field with a fixed priority. When a fetch misses, the surrounding memory management logic fetches the translation from the larger unified cache and presents it on the refill port. The block writes it into the victim slot and marks that slot most recently used.

Software maintenance uses two other paths. A memory-mapped port reads and writes the address word and the data word of any entry. A separate load port writes the ordering field directly. Fault signalling and the refill source stay outside this block.

Top module: `itlb_quad`

## Requirements
- R1: An entry takes part in matching only when its valid bit is set and at least one of these holds: its 8-bit space tag equals `lk_asid`, its shared bit is set, or `lk_asid_chk` is 0.
- R2: The page-size code picks the page: 0 is 1 KB, 1 is 4 KB, 2 is 64 KB and 3 is 1 MB. The match range starts at the entry's page number shifted left by 10 with the offset bits cleared, and is one page long. On a hit, `lk_paddr` is the entry's frame number shifted left by 10 with the offset bits cleared, OR the offset bits of `lk_vaddr`. `lk_user_x` is the entry's permission bit.
- R3: While `lk_valid` is 1, exactly one of `lk_hit`, `lk_miss` and `lk_multi` is 1. Two or more matching entries give `lk_multi`, not a hit. `lk_idx` gives the matching entry on a hit. While `lk_valid` is 0, all three are 0.
- R4: `lru_state` bits 5..0 are the ordering field. A single-match lookup updates it on the next edge. Entry 0 clears bits 5:3. Entry 1 sets bit 5 and clears bits 2:1. Entry 2 sets bits 4 and 2 and clears bit 0. Entry 3 sets bits 3, 1 and 0. A lookup with no match or with several matches leaves the field unchanged.
- R5: `victim_idx` is decoded from the field in this priority order: 0 when bits 5:3 are all 1; 1 when bit 5 is 0 and bits 2 and 1 are 1; 2 when bits 4 and 2 are 0 and bit 0 is 1; 3 when bits 3, 1 and 0 are all 0.
- R6: When none of the R5 patterns applies, `lru_err` is 1 and `victim_idx` is 0. Otherwise `lru_err` is 0.
- R7: A refill writes the presented translation, marked valid, into the slot `victim_idx` named before the edge. It then applies that slot's R4 update to the field.
- R8: The memory-mapped port reads combinationally and writes on the edge. With `mm_sel`=0 it selects the address word: bits 31:10 page number, bit 8 valid, bits 7:0 tag. With `mm_sel`=1 it selects the data word: bits 28:10 frame number, bit 8 valid, bits 7:6 size code, bit 5 permission, bit 1 shared. All other bits read as 0. A write changes only the fields of the selected word and leaves the ordering field unchanged.
- R9: `lru_we` loads `lru_wdata` into the ordering field on the next edge.
- R10: At most one action takes effect per cycle, in this priority order: field load, memory-mapped write, refill, lookup update. A lower-priority request in the same cycle is ignored.
- R11: After reset every entry reads as all zeros and is invalid, and the ordering field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Fetch virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_asid_chk | input | 1 | 1 = compare tags of non-shared entries |
| lk_hit | output | 1 | Exactly one entry matched |
| lk_miss | output | 1 | No entry matched |
| lk_multi | output | 1 | Two or more entries matched |
| lk_idx | output | 2 | Matching entry on a hit |
| lk_paddr | output | 29 | Translated physical address on a hit |
| lk_user_x | output | 1 | Permission bit of the matching entry |
| rf_valid | input | 1 | Refill request |
| rf_vpn | input | 22 | Refill page number |
| rf_asid | input | 8 | Refill tag |
| rf_ppn | input | 19 | Refill frame number |
| rf_sz | input | 2 | Refill page-size code |
| rf_sh | input | 1 | Refill shared bit |
| rf_pr | input | 1 | Refill permission bit |
| victim_idx | output | 2 | Slot the next refill will use |
| lru_err | output | 1 | Ordering field holds an undecodable pattern |
| mm_we | input | 1 | Memory-mapped write strobe |
| mm_sel | input | 1 | 0 = address word, 1 = data word |
| mm_idx | input | 2 | Entry selected by the memory-mapped port |
| mm_wdata | input | 32 | Memory-mapped write data |
| mm_rdata | output | 32 | Memory-mapped read data |
| lru_we | input | 1 | Ordering field load strobe |
| lru_wdata | input | 6 | Ordering field load value |
| lru_state | output | 6 | Current ordering field |

## Verification
A wrong ordering field shows up right away on `victim_idx` and `lru_err`, because both are decoded combinationally from it. It also shows as a bad `lru_state` on the edge after the hit or refill that produced it. A corrupted entry shows on the next lookup as a wrong outcome, index or `lk_paddr`, and on any memory-mapped read of that slot. A refill into the wrong slot is caught in the cycle after the refill: the readback of the expected slot and the advanced field both disagree with the bench's model. The sweeps cover all 64 field values, both for victim decoding and for the update applied by each of the four entries.

// File: rtl/itlbq_pkg.sv
package itlbq_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 29;
  localparam int ASID_W  = 8;
  localparam int PG_SH   = 10;
  localparam int NUM_ENT = 4;
  localparam int IDX_W   = $clog2(NUM_ENT);
  localparam int LRU_W   = 6;
  localparam int SZ_W    = 2;
  localparam int VPN_W   = VA_W - PG_SH;
  localparam int PPN_W   = PA_W - PG_SH;
  localparam int CNT_W   = $clog2(NUM_ENT + 1);

  typedef struct packed {
    logic              v;
    logic [VPN_W-1:0]  vpn;
    logic [ASID_W-1:0] asid;
    logic [PPN_W-1:0]  ppn;
    logic [SZ_W-1:0]   sz;
    logic              sh;
    logic              pr;
  } tlb_ent_t;

  // number of offset bits for a page-size code
  function automatic int pg_bits(input logic [SZ_W-1:0] sz);
    case (sz)
      2'd0:    pg_bits = PG_SH;
      2'd1:    pg_bits = PG_SH + 2;
      2'd2:    pg_bits = PG_SH + 6;
      default: pg_bits = PG_SH + 10;
    endcase
  endfunction

  function automatic logic [VA_W-1:0] va_off_mask(input logic [SZ_W-1:0] sz);
    va_off_mask = ~({VA_W{1'b1}} << pg_bits(sz));
  endfunction

  function automatic logic [PA_W-1:0] pa_off_mask(input logic [SZ_W-1:0] sz);
    pa_off_mask = ~({PA_W{1'b1}} << pg_bits(sz));
  endfunction

  // ordering-field update applied when entry k becomes most recent
  function automatic logic [LRU_W-1:0] lru_touch(input logic [LRU_W-1:0] s,
                                                 input logic [IDX_W-1:0] k);
    case (k)
      2'd0:    lru_touch = s & 6'b000111;
      2'd1:    lru_touch = (s & 6'b111001) | 6'b100000;
      2'd2:    lru_touch = (s & 6'b111110) | 6'b010100;
      default: lru_touch = s | 6'b001011;
    endcase
  endfunction
endpackage

// File: rtl/itlbq_lru.sv
module itlbq_lru
  import itlbq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_en,
  input  logic [LRU_W-1:0] ld_val,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  output logic [LRU_W-1:0] state,
  output logic [IDX_W-1:0] victim,
  output logic             bad
);
  logic [LRU_W-1:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (ld_en)       state_d = ld_val;
    else if (upd_en) state_d = lru_touch(state_q, upd_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                state_q <= '0;
    else if (ld_en || upd_en)  state_q <= state_d;
  end

  // victim decode, priority from slot 0 upward
  always_comb begin
    bad    = 1'b0;
    victim = '0;
    if (state_q[5:3] == 3'b111)
      victim = 2'd0;
    else if (!state_q[5] && state_q[2] && state_q[1])
      victim = 2'd1;
    else if (!state_q[4] && !state_q[2] && state_q[0])
      victim = 2'd2;
    else if (!state_q[3] && !state_q[1] && !state_q[0])
      victim = 2'd3;
    else begin
      bad    = 1'b1;
      victim = 2'd0;
    end
  end

  assign state = state_q;
endmodule

// File: rtl/itlbq_cam.sv
module itlbq_cam
  import itlbq_pkg::*;
(
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  input  logic              asid_chk,
  input  logic [NUM_ENT-1:0] v_vec,
  input  logic [NUM_ENT-1:0] sh_vec,
  input  logic [VPN_W-1:0]  vpn_arr  [NUM_ENT],
  input  logic [ASID_W-1:0] asid_arr [NUM_ENT],
  input  logic [SZ_W-1:0]   sz_arr   [NUM_ENT],
  output logic [NUM_ENT-1:0] match_vec,
  output logic              any_match,
  output logic              multi_match,
  output logic [IDX_W-1:0]  match_idx
);
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_cmp
    logic [VA_W-1:0] base_w;
    logic            tag_ok;
    logic            rng_ok;
    assign base_w = {vpn_arr[e], {PG_SH{1'b0}}};
    assign tag_ok = !asid_chk || sh_vec[e] || (asid_arr[e] == asid);
    assign rng_ok = ((va ^ base_w) & ~va_off_mask(sz_arr[e])) == '0;
    assign match_vec[e] = v_vec[e] && tag_ok && rng_ok;
  end

  logic [CNT_W-1:0] cnt;

  always_comb begin
    cnt       = '0;
    match_idx = '0;
    for (int e = 0; e < NUM_ENT; e++) begin
      if (match_vec[e]) begin
        cnt       = cnt + CNT_W'(1);
        match_idx = IDX_W'(e);
      end
    end
  end

  assign any_match   = (cnt != '0);
  assign multi_match = (cnt > CNT_W'(1));
endmodule

// File: rtl/itlbq_store.sv
module itlbq_store
  import itlbq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  tlb_ent_t         wr_ent,
  output tlb_ent_t         ents [NUM_ENT]
);
  tlb_ent_t ent_q [NUM_ENT];
  tlb_ent_t ent_d [NUM_ENT];

  always_comb begin
    for (int e = 0; e < NUM_ENT; e++) begin
      ent_d[e] = ent_q[e];
      if (wr_en && (wr_idx == IDX_W'(e))) ent_d[e] = wr_ent;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NUM_ENT; e++) ent_q[e] <= '0;
    end else if (wr_en) begin
      for (int e = 0; e < NUM_ENT; e++) ent_q[e] <= ent_d[e];
    end
  end

  assign ents = ent_q;
endmodule

// File: rtl/itlb_quad.sv
module itlb_quad
  import itlbq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_asid_chk,
  output logic              lk_hit,
  output logic              lk_miss,
  output logic              lk_multi,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [PA_W-1:0]   lk_paddr,
  output logic              lk_user_x,
  input  logic              rf_valid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [PPN_W-1:0]  rf_ppn,
  input  logic [SZ_W-1:0]   rf_sz,
  input  logic              rf_sh,
  input  logic              rf_pr,
  output logic [IDX_W-1:0]  victim_idx,
  output logic              lru_err,
  input  logic              mm_we,
  input  logic              mm_sel,
  input  logic [IDX_W-1:0]  mm_idx,
  input  logic [31:0]       mm_wdata,
  output logic [31:0]       mm_rdata,
  input  logic              lru_we,
  input  logic [LRU_W-1:0]  lru_wdata,
  output logic [LRU_W-1:0]  lru_state
);
  tlb_ent_t ents [NUM_ENT];
  tlb_ent_t wr_ent, mm_ent, rf_ent, hit_ent, sel_ent;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;

  logic [NUM_ENT-1:0] v_vec, sh_vec, match_vec;
  logic [VPN_W-1:0]   vpn_arr  [NUM_ENT];
  logic [ASID_W-1:0]  asid_arr [NUM_ENT];
  logic [SZ_W-1:0]    sz_arr   [NUM_ENT];
  logic               any_match, multi_match;
  logic [IDX_W-1:0]   match_idx;

  logic act_mm, act_rf, act_hit;
  logic [PA_W-1:0] pmask;

  logic unused_wbits;
  assign unused_wbits = ^{mm_wdata[9], mm_wdata[4:2], mm_wdata[0], match_vec};

  // fan entry fields out to the comparators
  for (genvar e = 0; e < NUM_ENT; e++) begin : g_fan
    assign v_vec[e]    = ents[e].v;
    assign sh_vec[e]   = ents[e].sh;
    assign vpn_arr[e]  = ents[e].vpn;
    assign asid_arr[e] = ents[e].asid;
    assign sz_arr[e]   = ents[e].sz;
  end

  itlbq_cam u_cam (
    .va          (lk_vaddr),
    .asid        (lk_asid),
    .asid_chk    (lk_asid_chk),
    .v_vec       (v_vec),
    .sh_vec      (sh_vec),
    .vpn_arr     (vpn_arr),
    .asid_arr    (asid_arr),
    .sz_arr      (sz_arr),
    .match_vec   (match_vec),
    .any_match   (any_match),
    .multi_match (multi_match),
    .match_idx   (match_idx)
  );

  // lookup outcome
  assign lk_hit   = lk_valid && any_match && !multi_match;
  assign lk_miss  = lk_valid && !any_match;
  assign lk_multi = lk_valid && multi_match;
  assign lk_idx   = lk_hit ? match_idx : '0;

  assign hit_ent   = ents[match_idx];
  assign pmask     = pa_off_mask(hit_ent.sz);
  assign lk_paddr  = lk_hit ? (({hit_ent.ppn, {PG_SH{1'b0}}} & ~pmask) |
                               (lk_vaddr[PA_W-1:0] & pmask)) : '0;
  assign lk_user_x = lk_hit && hit_ent.pr;

  // one action per cycle: load > mm write > refill > lookup update
  assign act_mm  = mm_we && !lru_we;
  assign act_rf  = rf_valid && !lru_we && !mm_we;
  assign act_hit = lk_hit && !lru_we && !mm_we && !rf_valid;

  // memory-mapped write merges one word into the selected entry
  assign sel_ent = ents[mm_idx];

  always_comb begin
    mm_ent = sel_ent;
    if (!mm_sel) begin
      mm_ent.vpn  = mm_wdata[VA_W-1:PG_SH];
      mm_ent.v    = mm_wdata[8];
      mm_ent.asid = mm_wdata[ASID_W-1:0];
    end else begin
      mm_ent.ppn  = mm_wdata[PA_W-1:PG_SH];
      mm_ent.v    = mm_wdata[8];
      mm_ent.sz   = mm_wdata[7:6];
      mm_ent.pr   = mm_wdata[5];
      mm_ent.sh   = mm_wdata[1];
    end
  end

  always_comb begin
    rf_ent.v    = 1'b1;
    rf_ent.vpn  = rf_vpn;
    rf_ent.asid = rf_asid;
    rf_ent.ppn  = rf_ppn;
    rf_ent.sz   = rf_sz;
    rf_ent.sh   = rf_sh;
    rf_ent.pr   = rf_pr;
  end

  assign wr_en  = act_mm || act_rf;
  assign wr_idx = act_mm ? mm_idx : victim_idx;
  assign wr_ent = act_mm ? mm_ent : rf_ent;

  itlbq_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_ent (wr_ent),
    .ents   (ents)
  );

  itlbq_lru u_lru (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (lru_we),
    .ld_val  (lru_wdata),
    .upd_en  (act_rf || act_hit),
    .upd_idx (act_rf ? victim_idx : match_idx),
    .state   (lru_state),
    .victim  (victim_idx),
    .bad     (lru_err)
  );

  // memory-mapped read
  always_comb begin
    if (!mm_sel)
      mm_rdata = {sel_ent.vpn, 1'b0, sel_ent.v, sel_ent.asid};
    else
      mm_rdata = {{(32-PA_W){1'b0}}, sel_ent.ppn, 1'b0, sel_ent.v,
                  sel_ent.sz, sel_ent.pr, 3'b000, sel_ent.sh, 1'b0};
  end
endmodule

// File: rtl/itlb_quad_chk.sv
module itlb_quad_chk
  import itlbq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             lk_valid,
  input logic             lk_hit,
  input logic             lk_miss,
  input logic             lk_multi,
  input logic [IDX_W-1:0] lk_idx,
  input logic             rf_valid,
  input logic             mm_we,
  input logic             lru_we,
  input logic [LRU_W-1:0] lru_wdata,
  input logic [LRU_W-1:0] lru_state,
  input logic [IDX_W-1:0] victim_idx,
  input logic             lru_err
);
  logic quiet;
  assign quiet = !lru_we && !mm_we && !rf_valid;

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({lk_hit, lk_miss, lk_multi}) == 1); // R3
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !(lk_hit || lk_miss || lk_multi)); // R3
  AST_HIT0_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_idx == 2'd0 && quiet) |=> lru_state[5:3] == 3'b000); // R4
  AST_HIT3_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && lk_idx == 2'd3 && quiet) |=> (lru_state[3] && lru_state[1] && lru_state[0])); // R4
  AST_MULTI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_multi && quiet) |=> $stable(lru_state)); // R4
  AST_ERR_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    lru_err |-> victim_idx == 2'd0); // R6
  AST_REFILL0_MRU: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_valid && !lru_we && !mm_we && victim_idx == 2'd0) |=> lru_state[5:3] == 3'b000); // R7
  AST_LOAD_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    lru_we |=> lru_state == $past(lru_wdata)); // R9
  AST_MM_KEEPS_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mm_we && !lru_we) |=> $stable(lru_state)); // R8
endmodule

bind itlb_quad itlb_quad_chk i_chk (.*);

// File: tb/test_itlb_quad.sv
module test_itlb_quad;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid, lk_asid_chk;
  logic [31:0] lk_vaddr;
  logic [7:0]  lk_asid;
  logic        lk_hit, lk_miss, lk_multi, lk_user_x;
  logic [1:0]  lk_idx;
  logic [28:0] lk_paddr;
  logic        rf_valid, rf_sh, rf_pr;
  logic [21:0] rf_vpn;
  logic [7:0]  rf_asid;
  logic [18:0] rf_ppn;
  logic [1:0]  rf_sz;
  logic [1:0]  victim_idx;
  logic        lru_err;
  logic        mm_we, mm_sel;
  logic [1:0]  mm_idx;
  logic [31:0] mm_wdata, mm_rdata;
  logic        lru_we;
  logic [5:0]  lru_wdata, lru_state;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // sampled lookup results
  logic        r_hit, r_miss, r_multi, r_ux;
  logic [1:0]  r_idx;
  logic [28:0] r_pa;

  always #(CLK_P/2) clk = ~clk;

  itlb_quad i_itlb_quad (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference model of the ordering field
  function automatic logic [5:0] m_touch(input logic [5:0] s, input int k);
    case (k)
      0: return s & 6'h07;
      1: return (s & 6'h39) | 6'h20;
      2: return (s & 6'h3E) | 6'h14;
      default: return s | 6'h0B;
    endcase
  endfunction

  function automatic int m_victim(input int s);
    if ((s >> 3) == 7) return 0;
    if (((s >> 5) & 1) == 0 && ((s >> 1) & 3) == 3) return 1;
    if (((s >> 4) & 1) == 0 && ((s >> 2) & 1) == 0 && (s & 1) == 1) return 2;
    if (((s >> 3) & 1) == 0 && (s & 3) == 0) return 3;
    return -1;
  endfunction

  function automatic logic [31:0] pg_size(input int sz);
    case (sz)
      0: return 32'd1024;
      1: return 32'd4096;
      2: return 32'd65536;
      default: return 32'd1048576;
    endcase
  endfunction

  function automatic logic [31:0] m_pa(input logic [18:0] ppn, input int sz, input logic [31:0] va);
    logic [31:0] sm;
    sm = pg_size(sz) - 1;
    return (({13'd0, ppn} << 10) & ~sm) | (va & sm) & 32'h1FFF_FFFF;
  endfunction

  task automatic idle_inputs();
    lk_valid = 0; lk_vaddr = '0; lk_asid = '0; lk_asid_chk = 1;
    rf_valid = 0; rf_vpn = '0; rf_asid = '0; rf_ppn = '0; rf_sz = '0; rf_sh = 0; rf_pr = 0;
    mm_we = 0; mm_sel = 0; mm_idx = '0; mm_wdata = '0;
    lru_we = 0; lru_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    idle_inputs();
    repeat (2) @(negedge clk);
    rst_n = 1;
    #1;
  endtask

  task automatic lru_load(input logic [5:0] v);
    @(negedge clk); lru_we = 1; lru_wdata = v;
    @(negedge clk); lru_we = 0; #1;
  endtask

  task automatic mm_write(input logic sel, input logic [1:0] idx, input logic [31:0] d);
    @(negedge clk); mm_we = 1; mm_sel = sel; mm_idx = idx; mm_wdata = d;
    @(negedge clk); mm_we = 0; #1;
  endtask

  task automatic mm_read(input logic sel, input logic [1:0] idx, output logic [31:0] d);
    @(negedge clk); mm_sel = sel; mm_idx = idx; #1; d = mm_rdata;
  endtask

  function automatic logic [31:0] aword(input logic [21:0] vpn, input logic v, input logic [7:0] a);
    return ({10'd0, vpn} << 10) | (32'(v) << 8) | 32'(a);
  endfunction

  function automatic logic [31:0] dword(input logic [18:0] ppn, input logic v, input logic [1:0] sz,
                                        input logic pr, input logic sh);
    return ({13'd0, ppn} << 10) | (32'(v) << 8) | (32'(sz) << 6) | (32'(pr) << 5) | (32'(sh) << 1);
  endfunction

  task automatic prog(input logic [1:0] k, input logic [21:0] vpn, input logic [7:0] a,
                      input logic [18:0] ppn, input logic [1:0] sz, input logic sh, input logic pr);
    mm_write(0, k, aword(vpn, 1'b1, a));
    mm_write(1, k, dword(ppn, 1'b1, sz, pr, sh));
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] a, input logic chk);
    @(negedge clk); lk_valid = 1; lk_vaddr = va; lk_asid = a; lk_asid_chk = chk; #1;
    r_hit = lk_hit; r_miss = lk_miss; r_multi = lk_multi; r_idx = lk_idx; r_pa = lk_paddr; r_ux = lk_user_x;
    @(negedge clk); lk_valid = 0; #1;
  endtask

  initial begin
    logic [31:0] rd;
    logic [31:0] base [4];
    logic [18:0] ppn_k [4];
    logic [5:0]  m_lru;
    rst_n = 0;
    idle_inputs();
    do_reset();

    // R11 reset state
    check("R11 field after reset", 32'(lru_state), 32'h0);
    for (int k = 0; k < 4; k++) begin
      mm_read(0, 2'(k), rd); check("R11 address word after reset", rd, 32'h0);
      mm_read(1, 2'(k), rd); check("R11 data word after reset", rd, 32'h0);
    end
    look(32'h0, 8'h0, 1'b0);
    check("R11 lookup misses after reset", {29'd0, r_hit, r_miss, r_multi}, 32'h2);

    // R5 R6 R9 sweep over every field value
    for (int s = 0; s < 64; s++) begin
      lru_load(6'(s));
      check("R9 field load", 32'(lru_state), 32'(s));
      if (m_victim(s) < 0) begin
        check("R6 error flag", 32'(lru_err), 32'h1);
        check("R6 fallback slot", 32'(victim_idx), 32'h0);
      end else begin
        check("R6 error flag clear", 32'(lru_err), 32'h0);
        check("R5 victim decode", 32'(victim_idx), 32'(m_victim(s)));
      end
    end

    // R8 program four 4 KB pages and read back
    for (int k = 0; k < 4; k++) begin
      base[k]  = 32'h0040_0000 + 32'(k) * 32'h0001_0000;
      ppn_k[k] = 19'h4000 + 19'(k * 8);
      prog(2'(k), base[k][31:10], 8'h10 + 8'(k), ppn_k[k], 2'd1, 1'b0, 1'(k & 1));
      mm_read(0, 2'(k), rd); check("R8 address word", rd, aword(base[k][31:10], 1'b1, 8'h10 + 8'(k)));
      mm_read(1, 2'(k), rd); check("R8 data word", rd, dword(ppn_k[k], 1'b1, 2'd1, 1'(k & 1), 1'b0));
    end

    // R8 memory-mapped write leaves the field alone
    lru_load(6'h2A);
    mm_write(0, 2'd0, aword(base[0][31:10], 1'b1, 8'h10));
    check("R8 field unchanged by mm write", 32'(lru_state), 32'h2A);

    // R3 R4 R2 each entry hit from every field value
    for (int s = 0; s < 64; s++) begin
      for (int k = 0; k < 4; k++) begin
        lru_load(6'(s));
        look(base[k] + 32'h123, 8'h10 + 8'(k), 1'b1);
        check("R3 single hit", {29'd0, r_hit, r_miss, r_multi}, 32'h4);
        check("R3 hit index", 32'(r_idx), 32'(k));
        check("R2 physical address", 32'(r_pa), m_pa(ppn_k[k], 1, base[k] + 32'h123));
        check("R2 permission bit", 32'(r_ux), 32'(k & 1));
        check("R4 field after hit", 32'(lru_state), 32'(m_touch(6'(s), k)));
      end
    end

    // R1 tag matching
    look(base[0], 8'h55, 1'b1);
    check("R1 tag mismatch misses", {29'd0, r_hit, r_miss, r_multi}, 32'h2);
    look(base[0], 8'h55, 1'b0);
    check("R1 tag check off hits", {29'd0, r_hit, r_miss, r_multi}, 32'h4);
    mm_write(1, 2'd0, dword(ppn_k[0], 1'b1, 2'd1, 1'b0, 1'b1));
    look(base[0], 8'h55, 1'b1);
    check("R1 shared entry hits", {29'd0, r_hit, r_miss, r_multi}, 32'h4);
    mm_write(0, 2'd1, aword(base[1][31:10], 1'b0, 8'h11));
    look(base[1], 8'h11, 1'b1);
    check("R1 invalid entry misses", {29'd0, r_hit, r_miss, r_multi}, 32'h2);

    // R2 page sizes and range edges on entry 2
    for (int sz = 0; sz < 4; sz++) begin
      logic [21:0] vpn;
      logic [31:0] st, psz;
      vpn = 22'((32'h0800_0000 >> 10) | 32'h3);
      psz = pg_size(sz);
      st  = ({10'd0, vpn} << 10) & ~(psz - 1);
      prog(2'd2, vpn, 8'h12, 19'h55555, 2'(sz), 1'b0, 1'b1);
      look(st, 8'h12, 1'b1);
      check("R2 first byte hits", {29'd0, r_hit, r_miss, r_multi}, 32'h4);
      check("R2 first byte address", 32'(r_pa), m_pa(19'h55555, sz, st));
      look(st + psz - 1, 8'h12, 1'b1);
      check("R2 last byte hits", {29'd0, r_hit, r_miss, r_multi}, 32'h4);
      check("R2 last byte address", 32'(r_pa), m_pa(19'h55555, sz, st + psz - 1));
      look(st + psz, 8'h12, 1'b1);
      check("R2 past end misses", {29'd0, r_hit, r_miss, r_multi}, 32'h2);
      look(st - 1, 8'h12, 1'b1);
      check("R2 before start misses", {29'd0, r_hit, r_miss, r_multi}, 32'h2);
    end

    // R3 R4 overlapping entries give multiple hit and hold the field
    prog(2'd3, 22'(32'h0800_0000 >> 10), 8'h12, 19'h1, 2'd3, 1'b0, 1'b0);
    lru_load(6'h15);
    look(32'h0800_0040, 8'h12, 1'b1);
    check("R3 multiple hit", {29'd0, r_hit, r_miss, r_multi}, 32'h1);
    check("R4 field held on multiple hit", 32'(lru_state), 32'h15);

    // R7 refills from reset, each into the decoded victim
    do_reset();
    m_lru = 6'h0;
    for (int i = 0; i < 6; i++) begin
      int v;
      v = m_victim(int'(m_lru));
      check("R7 victim before refill", 32'(victim_idx), 32'(v));
      @(negedge clk);
      rf_valid = 1; rf_vpn = 22'h100 + 22'(i * 4); rf_asid = 8'h30 + 8'(i);
      rf_ppn = 19'h200 + 19'(i); rf_sz = 2'd1; rf_sh = 1'(i & 1); rf_pr = 1'b1;
      @(negedge clk); rf_valid = 0; #1;
      m_lru = m_touch(m_lru, v);
      check("R7 field after refill", 32'(lru_state), 32'(m_lru));
      mm_read(0, 2'(v), rd);
      check("R7 refilled address word", rd, aword(22'h100 + 22'(i * 4), 1'b1, 8'h30 + 8'(i)));
      mm_read(1, 2'(v), rd);
      check("R7 refilled data word", rd, dword(19'h200 + 19'(i), 1'b1, 2'd1, 1'b1, 1'(i & 1)));
    end

    // R10 priority between simultaneous requests
    do_reset();
    @(negedge clk);
    mm_we = 1; mm_sel = 0; mm_idx = 2'd0; mm_wdata = aword(22'h3A, 1'b1, 8'h7);
    rf_valid = 1; rf_vpn = 22'h99; rf_asid = 8'h1; rf_ppn = 19'h9; rf_sz = 2'd0; rf_sh = 0; rf_pr = 0;
    @(negedge clk); mm_we = 0; rf_valid = 0; #1;
    check("R10 mm write wins over refill: field", 32'(lru_state), 32'h0);
    mm_read(0, 2'd3, rd); check("R10 refill ignored under mm write", rd, 32'h0);
    mm_read(0, 2'd0, rd); check("R10 mm write applied", rd, aword(22'h3A, 1'b1, 8'h7));
    @(negedge clk);
    lru_we = 1; lru_wdata = 6'h27; rf_valid = 1;
    mm_we = 1; mm_sel = 0; mm_idx = 2'd1; mm_wdata = aword(22'h55, 1'b1, 8'h9);
    @(negedge clk); lru_we = 0; rf_valid = 0; mm_we = 0; #1;
    check("R10 field load wins", 32'(lru_state), 32'h27);
    mm_read(0, 2'd1, rd); check("R10 mm write ignored under load", rd, 32'h0);
    mm_read(0, 2'd3, rd); check("R10 refill ignored under load", rd, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule